// File: doc/BRIEF.md
# SPI FIFO Threshold Interrupt and Status Unit

This unit sits between a register port and the serial shift engine of an SPI controller. Software writes transmit words into a TX FIFO and reads received words out of an RX FIFO. The engine drains the TX FIFO and fills the RX FIFO through single-cycle strobes. Both FIFOs are `DEPTH` words of `WIDTH` bits. The unit derives five status flags from the FIFO fill levels. It also maintains four interrupt sources, a mask, a masked view of the sources, and a single interrupt line.

Two of the sources are level conditions that are evaluated live, each against a programmable trigger level: RX filled to its trigger, and TX drained to its trigger. The other two are sticky error flags:
- Receive overflow is set when the engine pushes into a full RX FIFO.
- Receive timeout is set when received data sits below its trigger with no FIFO activity for `TO_TICKS` engine ticks.

Writing 1 to the clear register removes a sticky flag. The enable register drives a single control output to the engine.

The timeout watcher is a three-state machine:
- `TO_IDLE` moves to `TO_COUNT` when the RX FIFO becomes armed, meaning it is non-empty and below its trigger.
- `TO_COUNT` moves back to `TO_IDLE` when disarmed. Any accepted RX push or pop restarts its count. On the tick that completes `TO_TICKS` quiet ticks it moves to `TO_FIRED` and sets the timeout flag.
- `TO_FIRED` holds until disarm or activity, then returns to `TO_IDLE`. Because it holds, a cleared timeout is not re-raised without new activity.

Top module: `fifo_irq_status`

Register map (word index on `reg_addr`):

| Index | Register | Access | Contents |
|---|---|---|---|
| 0 | enable | read/write | bit 0 |
| 1 | FIFO control | read/write | RX trigger code in bits 11:9, TX trigger code in bits 5:3 |
| 2 | mask | read/write | bits 3:0 |
| 3 | TX data | write | a write pushes one word |
| 4 | RX data | read | a read with `reg_rd` pops one word |
| 5 | status | read | bits 4:0 |
| 6 | raw interrupts | read | bits 3:0 |
| 7 | masked interrupts | read | bits 3:0 |
| 8 | clear | write | bits 1:0 |

Other registers read 0.

## Requirements
- R1: After reset the mask reads 4'hF, the enable bit reads 0, the raw interrupt register reads 4'b1000, the masked register reads 0, status reads 5'b00011, and `irq` is 0.
- R2: Words written to TX data leave on `eng_tx_data` in write order. Words pushed by the engine are returned by RX-data reads in push order.
- R3: Raw bit 2 is 1 exactly when the RX count is at least the RX trigger level. The level is chosen by FIFO-control bits 11:9: codes 0 to 6 select 1, 4, 8, 16, 32, 64 and 128, and code 7 selects 128.
- R4: Raw bit 3 is 1 exactly when the TX count is at most the TX trigger level. The level is chosen by FIFO-control bits 5:3 using the same code table.
- R5: An engine push into a full RX FIFO drops the word and sets raw bit 0, which stays set until cleared.
- R6: With the RX FIFO non-empty and below its trigger, `TO_TICKS` `eng_tick` cycles with no accepted RX push or pop set raw bit 1. One tick fewer does not, an accepted push or pop restarts the count, and an RX FIFO at or above its trigger never times out.
- R7: Writing the clear register with bit 0 or bit 1 set clears only the matching sticky flag. A cleared timeout is not raised again until new RX activity.
- R8: The masked register equals raw AND NOT mask (a mask bit of 1 hides a source), and `irq` is 1 exactly when the masked register is non-zero.
- R9: Status bits are: bit 0 TX empty, bit 1 TX not full, bit 2 RX not empty, bit 3 RX full, bit 4 the `eng_busy` input.
- R10: Enable bit 0 drives `xfer_en` from the cycle after the write.
- R11: A TX-data write into a full TX FIFO is dropped. An RX-data read of an empty RX FIFO returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (pops RX on index 4) |
| reg_addr | input | 4 | register word index |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data, combinational from `reg_addr` |
| xfer_en | output | 1 | transfer enable to the engine |
| eng_tx_pop | input | 1 | engine takes the TX head word |
| eng_tx_valid | output | 1 | TX FIFO not empty |
| eng_tx_data | output | WIDTH | TX head word |
| eng_rx_push | input | 1 | engine delivers a received word |
| eng_rx_data | input | WIDTH | received word |
| eng_busy | input | 1 | engine busy flag, reported in status |
| eng_tick | input | 1 | one serial-clock-equivalent period elapsed |
| irq | output | 1 | interrupt, OR of masked sources |

## Verification
The bench keeps the default 256-word depth so that every trigger code up to 128 sits inside the FIFO. This lets both sides of each level boundary be reached, along with the exact full point at which overflow and TX drop happen. It reduces `TO_TICKS` to 8, which places the last quiet tick before expiry, the expiring tick and a mid-count restart within a few dozen cycles.

// File: rtl/fifo_irq_pkg.sv
`timescale 1ns/1ps
package fifo_irq_pkg;
    typedef enum logic [1:0] {TO_IDLE, TO_COUNT, TO_FIRED} to_state_e;

    localparam int SRC_OVF = 0;
    localparam int SRC_TO  = 1;
    localparam int SRC_RXL = 2;
    localparam int SRC_TXL = 3;

    localparam logic [3:0] A_EN    = 4'd0;
    localparam logic [3:0] A_FCTL  = 4'd1;
    localparam logic [3:0] A_MASK  = 4'd2;
    localparam logic [3:0] A_TXD   = 4'd3;
    localparam logic [3:0] A_RXD   = 4'd4;
    localparam logic [3:0] A_STAT  = 4'd5;
    localparam logic [3:0] A_RAW   = 4'd6;
    localparam logic [3:0] A_MSKD  = 4'd7;
    localparam logic [3:0] A_CLR   = 4'd8;

    // trigger code -> level; codes above 6 saturate at 128
    function automatic logic [7:0] trig_level(input logic [2:0] code);
        if (code == 3'd0)      return 8'd1;
        else if (code >= 3'd6) return 8'd128;
        else                   return 8'd2 << code;
    endfunction
endpackage

// File: rtl/fis_fifo.sv
`timescale 1ns/1ps
module fis_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 256,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          push_ok,
    output logic          pop_ok
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rptr_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
            if (pop_ok)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    assert_full_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full);
    assert_empty_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);
endmodule

// File: rtl/fis_timeout.sv
`timescale 1ns/1ps
module fis_timeout
    import fifo_irq_pkg::*;
#(
    parameter int TO_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic activity,
    input  logic tick,
    output logic fire
);
    localparam int TW = (TO_TICKS > 1) ? $clog2(TO_TICKS) : 1;
    localparam logic [TW-1:0] CNT_LAST = TW'(TO_TICKS - 1);

    to_state_e   state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TO_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        unique case (state_q)
            TO_IDLE: begin
                if (armed) begin
                    state_d = TO_COUNT;
                    cnt_d   = '0;
                end
            end
            TO_COUNT: begin
                if (!armed) begin
                    state_d = TO_IDLE;
                end else if (activity) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == CNT_LAST) begin
                        state_d = TO_FIRED;
                        fire    = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            TO_FIRED: begin
                if (!armed || activity) state_d = TO_IDLE;
            end
            default: state_d = TO_IDLE;
        endcase
    end

    assert_fired_via_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TO_FIRED && $past(state_q) != TO_FIRED) |-> $past(state_q) == TO_COUNT);
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TO_IDLE) |-> !fire);
endmodule

// File: rtl/fis_irq_core.sv
`timescale 1ns/1ps
module fis_irq_core
    import fifo_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovf_set,
    input  logic       to_set,
    input  logic       rx_lvl,
    input  logic       tx_lvl,
    input  logic       clr_wr,
    input  logic [1:0] clr_bits,
    input  logic       mask_wr,
    input  logic [3:0] mask_wdata,
    output logic [3:0] mask,
    output logic [3:0] raw,
    output logic [3:0] masked,
    output logic       irq
);
    logic       ovf_q, to_q;
    logic [3:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q  <= 1'b0;
            to_q   <= 1'b0;
            mask_q <= 4'hF;
        end else begin
            ovf_q <= ovf_set | (ovf_q & ~(clr_wr & clr_bits[0]));
            to_q  <= to_set  | (to_q  & ~(clr_wr & clr_bits[1]));
            if (mask_wr) mask_q <= mask_wdata;
        end
    end

    always_comb begin
        raw          = '0;
        raw[SRC_OVF] = ovf_q;
        raw[SRC_TO]  = to_q;
        raw[SRC_RXL] = rx_lvl;
        raw[SRC_TXL] = tx_lvl;
        masked       = raw & ~mask_q;
        irq          = |masked;
        mask         = mask_q;
    end

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(clr_wr && clr_bits[0])) |=> ovf_q);
    assert_ovf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> raw[SRC_OVF]);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_bits[1] && !to_set) |=> !to_q);
    assert_all_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 4'hF) |-> !irq);
endmodule

// File: rtl/fifo_irq_status.sv
`timescale 1ns/1ps
module fifo_irq_status
    import fifo_irq_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int DEPTH    = 256,
    parameter int TO_TICKS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             xfer_en,
    input  logic             eng_tx_pop,
    output logic             eng_tx_valid,
    output logic [WIDTH-1:0] eng_tx_data,
    input  logic             eng_rx_push,
    input  logic [WIDTH-1:0] eng_rx_data,
    input  logic             eng_busy,
    input  logic             eng_tick,
    output logic             irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          en_q;
    logic [2:0]    rx_code_q, tx_code_q;
    logic          tx_push, rx_pop;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic [WIDTH-1:0] rx_head;
    logic          rx_lvl, tx_lvl, armed, to_fire;
    logic [3:0]    mask, raw, masked;

    assign tx_push = reg_wr && (reg_addr == A_TXD);
    assign rx_pop  = reg_rd && (reg_addr == A_RXD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            rx_code_q <= '0;
            tx_code_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_EN) en_q <= reg_wdata[0];
            if (reg_addr == A_FCTL) begin
                rx_code_q <= reg_wdata[11:9];
                tx_code_q <= reg_wdata[5:3];
            end
        end
    end
    assign xfer_en = en_q;

    fis_fifo #(.W(WIDTH), .DEPTH(DEPTH), .CW(CW)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .din(reg_wdata[WIDTH-1:0]),
        .pop(eng_tx_pop), .dout(eng_tx_data),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok));

    fis_fifo #(.W(WIDTH), .DEPTH(DEPTH), .CW(CW)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(eng_rx_push), .din(eng_rx_data),
        .pop(rx_pop), .dout(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok));

    assign eng_tx_valid = !tx_empty;
    assign rx_lvl = 32'(rx_cnt) >= 32'(trig_level(rx_code_q));
    assign tx_lvl = 32'(tx_cnt) <= 32'(trig_level(tx_code_q));
    assign armed  = !rx_empty && !rx_lvl;

    fis_timeout #(.TO_TICKS(TO_TICKS)) u_to (
        .clk(clk), .rst_n(rst_n), .armed(armed),
        .activity(rx_push_ok | rx_pop_ok), .tick(eng_tick), .fire(to_fire));

    fis_irq_core u_irq (
        .clk(clk), .rst_n(rst_n),
        .ovf_set(eng_rx_push && rx_full), .to_set(to_fire),
        .rx_lvl(rx_lvl), .tx_lvl(tx_lvl),
        .clr_wr(reg_wr && reg_addr == A_CLR), .clr_bits(reg_wdata[1:0]),
        .mask_wr(reg_wr && reg_addr == A_MASK), .mask_wdata(reg_wdata[3:0]),
        .mask(mask), .raw(raw), .masked(masked), .irq(irq));

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_EN:   reg_rdata[0] = en_q;
            A_FCTL: begin
                reg_rdata[11:9] = rx_code_q;
                reg_rdata[5:3]  = tx_code_q;
            end
            A_MASK: reg_rdata[3:0] = mask;
            A_RXD:  if (!rx_empty) reg_rdata[WIDTH-1:0] = rx_head;
            A_STAT: reg_rdata[4:0] = {eng_busy, rx_full, !rx_empty, !tx_full, tx_empty};
            A_RAW:  reg_rdata[3:0] = raw;
            A_MSKD: reg_rdata[3:0] = masked;
            default: reg_rdata = '0;
        endcase
    end

    assert_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_EN) |=> (xfer_en == $past(reg_wdata[0])));
    assert_rx_empty_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty && !eng_rx_push) |=> $stable(rx_cnt));
    assert_ovf_from_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full && !rx_pop) |=> (raw[SRC_OVF] && rx_full));
endmodule

// File: tb/fifo_irq_status_bench.sv
`timescale 1ns/1ps
module fifo_irq_status_bench;
    localparam int DEPTH = 256;
    localparam int W     = 32;
    localparam int TOT   = 8;
    localparam logic [3:0] EN = 0, FCTL = 1, MSK = 2, TXD = 3, RXD = 4,
                           STAT = 5, RAW = 6, MSKD = 7, CLR = 8;

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [3:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic xfer_en, eng_tx_valid, irq;
    logic eng_tx_pop = 0, eng_rx_push = 0, eng_busy = 0, eng_tick = 0;
    logic [W-1:0] eng_tx_data, eng_rx_data = 0;

    always #4 clk = ~clk;

    fifo_irq_status #(.WIDTH(W), .DEPTH(DEPTH), .TO_TICKS(TOT)) u_fifo_irq_status (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_en(xfer_en), .eng_tx_pop(eng_tx_pop), .eng_tx_valid(eng_tx_valid),
        .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_busy(eng_busy), .eng_tick(eng_tick),
        .irq(irq));

    int vectors = 0, fails = 0;
    bit finished = 0;
    logic [31:0] txq[$], rxq[$];
    logic exp_ovf, exp_to;
    logic [3:0] exp_mask;
    logic [2:0] rxc, txc;

    function automatic int lvl(input logic [2:0] c);
        if (c == 0) return 1;
        if (c >= 6) return 128;
        return 2 << c;
    endfunction
    function automatic logic [3:0] exp_raw();
        return {logic'(txq.size() <= lvl(txc)), logic'(rxq.size() >= lvl(rxc)), exp_to, exp_ovf};
    endfunction
    function automatic logic [4:0] exp_stat();
        return {eng_busy, logic'(rxq.size() == DEPTH), logic'(rxq.size() != 0),
                logic'(txq.size() != DEPTH), logic'(txq.size() == 0)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask
    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask
    task automatic tx_write(input logic [31:0] d);
        wr(TXD, d);
        if (txq.size() < DEPTH) txq.push_back(d);
    endtask
    task automatic rx_read(input string req);
        logic [31:0] d, e;
        e = (rxq.size() != 0) ? rxq.pop_front() : 32'h0;
        rd(RXD, d);
        check(req, d, e);
    endtask
    task automatic eng_push(input logic [31:0] d);
        eng_rx_data = d; eng_rx_push = 1;
        @(negedge clk);
        eng_rx_push = 0;
        if (rxq.size() < DEPTH) rxq.push_back(d); else exp_ovf = 1;
    endtask
    task automatic eng_pop(input string req);
        check(req, {31'b0, eng_tx_valid}, {31'b0, logic'(txq.size() != 0)});
        if (txq.size() != 0) check(req, eng_tx_data, txq.pop_front());
        eng_tx_pop = 1;
        @(negedge clk);
        eng_tx_pop = 0;
    endtask
    task automatic set_codes(input logic [2:0] r, input logic [2:0] t);
        wr(FCTL, {20'b0, r, 3'b0, t, 3'b0});
        rxc = r; txc = t;
    endtask
    task automatic check_regs(input string req);
        logic [31:0] d;
        rd(RAW, d);  check({req, " raw"}, d, {28'b0, exp_raw()});
        rd(MSKD, d); check({req, " masked"}, d, {28'b0, exp_raw() & ~exp_mask});
        check({req, " irq R8"}, {31'b0, irq}, {31'b0, logic'(|(exp_raw() & ~exp_mask))});
        rd(STAT, d); check({req, " status R9"}, d, {27'b0, exp_stat()});
    endtask
    task automatic do_reset();
        rst_n = 0; txq.delete(); rxq.delete();
        exp_ovf = 0; exp_to = 0; exp_mask = 4'hF; rxc = 0; txc = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask
    task automatic ticks(input int n);
        eng_tick = 1;
        repeat (n) @(negedge clk);
        eng_tick = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int unsigned seed;
        @(negedge clk);
        do_reset();
        // R1 reset state
        rd(MSK, d); check("R1 mask", d, 32'hF);
        rd(EN, d);  check("R1 enable", d, 0);
        check("R1 xfer_en", {31'b0, xfer_en}, 0);
        check_regs("R1");

        // R10 enable
        wr(EN, 1); check("R10 en on", {31'b0, xfer_en}, 1);
        rd(EN, d); check("R10 readback", d, 1);
        wr(EN, 0); check("R10 en off", {31'b0, xfer_en}, 0);

        // R3 RX trigger levels, both sides of every boundary
        for (int c = 0; c < 8; c++) begin
            do_reset();
            set_codes(3'(c), 0);
            for (int i = 0; i < lvl(3'(c)) - 1; i++) eng_push(32'(i * 7 + c));
            check_regs("R3 below");
            eng_push(32'hABC);
            check_regs("R3 at");
        end

        // R4 TX trigger levels
        for (int c = 0; c < 8; c++) begin
            do_reset();
            set_codes(0, 3'(c));
            for (int i = 0; i < lvl(3'(c)) + 1; i++) tx_write(32'(i + 100 * c));
            check_regs("R4 above");
            eng_pop("R2 tx order");
            check_regs("R4 at");
        end

        // R5 overflow, R2 rx order, R7 selective clear
        do_reset();
        for (int i = 0; i < DEPTH; i++) eng_push(32'h1000 + 32'(i));
        check_regs("R5 full no ovf");
        eng_push(32'hDEAD_BEEF);
        check_regs("R5 ovf set");
        for (int i = 0; i < DEPTH; i++) rx_read("R2 rx order");
        check_regs("R5 sticky after drain");
        wr(CLR, 32'h2);
        check_regs("R7 clear other bit keeps ovf");
        wr(CLR, 32'h1); exp_ovf = 0;
        check_regs("R7 clear ovf");

        // R11 empty read and full TX drop
        rx_read("R11 empty read zero");
        check_regs("R11 empty read no effect");
        for (int i = 0; i < DEPTH + 1; i++) tx_write(32'h5000 + 32'(i));
        check_regs("R11 tx full");
        for (int i = 0; i < DEPTH; i++) eng_pop("R11 tx order without dropped word");
        check_regs("R11 tx drained");

        // R6 timeout
        do_reset();
        set_codes(2, 0);
        eng_push(32'h77);
        repeat (2) @(negedge clk);
        ticks(TOT - 1);
        check_regs("R6 one tick short");
        ticks(1); exp_to = 1;
        check_regs("R6 expiry");
        wr(CLR, 32'h2); exp_to = 0;
        check_regs("R7 clear timeout");
        ticks(TOT + 2);
        check_regs("R7 no re-raise without activity");
        eng_push(32'h78);
        repeat (2) @(negedge clk);
        ticks(TOT - 1);
        eng_push(32'h79);
        ticks(TOT - 1);
        check_regs("R6 activity restarts count");
        ticks(1); exp_to = 1;
        check_regs("R6 expiry after restart");
        wr(CLR, 32'h2); exp_to = 0;
        for (int i = 0; i < 5; i++) eng_push(32'h80 + 32'(i));
        ticks(TOT + 3);
        check_regs("R6 at trigger no timeout");

        // R8 every mask value
        exp_ovf = 0;
        for (int m = 0; m < 16; m++) begin
            wr(MSK, 32'(m)); exp_mask = 4'(m);
            rd(MSK, d); check("R8 mask readback", d, 32'(m));
            check_regs("R8 mask");
        end

        // Random mix, no ticks
        do_reset();
        seed = $urandom(32'd20240611);
        for (int n = 0; n < 4000; n++) begin
            int unsigned op;
            op = $urandom_range(0, 9);
            case (op)
                0, 1: tx_write($urandom());
                2, 3: eng_pop("R2 random tx");
                4, 5: eng_push($urandom());
                6, 7: rx_read("R2 random rx");
                8: set_codes(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)));
                default: begin
                    wr(MSK, 32'($urandom_range(0, 15))); exp_mask = reg_wdata[3:0];
                    eng_busy = 1'($urandom_range(0, 1));
                end
            endcase
            if (n % 8 == 0) check_regs("R3 R4 R9 random");
        end

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule